// File: doc/BRIEF.md
# Program Fetch Memory Router

This block connects one CPU instruction-fetch port to three program storage regions inside a 24-bit linear code space. The regions are a small on-chip ROM at the bottom of the space, an on-chip RAM at the top of the first 64 KB, and an off-chip memory that owns every other address. A request is accepted on a valid/ready handshake. The router decodes the address, drives the strobe and offset of the matching region, and returns one response per accepted request.

The two on-chip regions answer one cycle after acceptance, so reads from them can be issued back to back. Off-chip accesses hold their strobe and address for at least the programmed wait count. They end only when that count has run out and the external ready line is high. While an off-chip access is open, `req_ready` is low, and the CPU must hold its request until `req_ready` returns high. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the CPU must take when it appears.

A write request with `req_write` high stores into the RAM or the off-chip memory, for example while a boot loader copies code. A write aimed at the ROM changes nothing. Every write is acknowledged with a response whose data is zero.

Top module: `pfetch_router`

## Requirements
- R1: After reset, `rsp_valid`, `ext_rd`, `ext_wr`, `ram_we` and `rom_en` are low and `req_ready` is high. `ext_rd` and `ext_wr` are never high together.
- R2: An address below ROM_BYTES selects the ROM. An address from 65536-RAM_BYTES to 0xFFFF selects the RAM. Every other address of the 24-bit space, including all addresses at or above 0x10000, selects the off-chip memory. The offset given to the RAM is the address minus 65536-RAM_BYTES.
- R3: A read from an on-chip region produces `rsp_valid` with the region's data in the cycle after acceptance. `req_ready` stays high, so a new request can be accepted in that same cycle.
- R4: An off-chip read holds `ext_rd` high and `ext_addr` equal to the request address, starting in the cycle after acceptance. With `ext_ready` high, the response comes 2+W cycles after acceptance, where W is the `wait_cfg` value at acceptance.
- R5: An off-chip access completes only in a cycle where the wait count has expired and `ext_ready` is high. If ready first rises S cycles into the access, the latency is 2+max(W,S).
- R6: While an off-chip access is open, `req_ready` is low and no new request is accepted.
- R7: A RAM write pulses `ram_we` for one cycle, in the acceptance cycle, with the RAM offset and the write data. A zero-data acknowledge follows one cycle later. A read of the same address accepted in the very next cycle returns the new data.
- R8: An off-chip write holds `ext_wr` and the write data with the same wait and ready timing as a read. It ends with a zero-data acknowledge.
- R9: A write to the ROM region raises neither `ram_we`, `ext_wr` nor `rom_en`. It is acknowledged one cycle after acceptance with zero data, and later ROM reads return unchanged data.
- R10: Each accepted request yields exactly one `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Fetch or write request present |
| req_ready | output | 1 | Router can accept a request this cycle |
| req_addr | input | 24 | Linear program address |
| req_write | input | 1 | 1 = program write, 0 = fetch |
| req_wdata | input | 8 | Byte to store on a write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 8 | Fetched byte, zero for write acknowledges |
| wait_cfg | input | 4 | Programmed off-chip wait cycles |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 16 | ROM byte offset |
| rom_rdata | input | 8 | ROM data, one cycle after enable |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM byte offset |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM data, one cycle after read enable |
| ext_rd | output | 1 | Off-chip read strobe, held for the access |
| ext_wr | output | 1 | Off-chip write strobe, held for the access |
| ext_addr | output | 24 | Off-chip address, held for the access |
| ext_wdata | output | 8 | Off-chip write data |
| ext_rdata | input | 8 | Off-chip read data |
| ext_ready | input | 1 | Off-chip device ready |

## Verification
Two overlaps are provoked on purpose.

In the first, the bench holds `req_valid` through consecutive on-chip requests, so the response to one request and the acceptance of the next fall in the same cycle. It does this both for two ROM reads and for a RAM write followed by a read of the same byte. The judge is that each response arrives exactly one cycle after its own acceptance and carries its own data: the acknowledge, then the newly written byte.

In the second, the wait count expiring and `ext_ready` rising are swept against each other over a grid of both delays. The measured latency must equal 2+max(W,S) whichever of the two comes last, and `req_ready` must stay low throughout.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    REG_ROM = 2'd0,
    REG_RAM = 2'd1,
    REG_EXT = 2'd2
  } pfr_region_e;
endpackage

// File: rtl/pfr_decode.sv
module pfr_decode
  import pfr_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int ROM_BYTES = 1024,
  parameter int RAM_BYTES = 4096,
  parameter int ROM_AW    = 10,
  parameter int RAM_AW    = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output pfr_region_e       region,
  output logic [ROM_AW-1:0] rom_off,
  output logic [RAM_AW-1:0] ram_off
);
  localparam int RAM_BASE = 65536 - RAM_BYTES;

  logic        low64;
  logic        rom_hit;
  logic        ram_hit;
  logic [15:0] ram_rel;

  assign low64 = (addr[ADDR_W-1:16] == '0);

  // a zero-sized region never claims an address
  if (ROM_BYTES == 0) begin : g_no_rom
    assign rom_hit = 1'b0;
  end else begin : g_rom
    assign rom_hit = low64 && ({1'b0, addr[15:0]} < 17'(ROM_BYTES));
  end

  if (RAM_BYTES == 0) begin : g_no_ram
    assign ram_hit = 1'b0;
  end else begin : g_ram
    assign ram_hit = low64 && ({1'b0, addr[15:0]} >= 17'(RAM_BASE));
  end

  assign ram_rel = addr[15:0] - 16'(RAM_BASE);
  assign rom_off = addr[ROM_AW-1:0];
  assign ram_off = ram_rel[RAM_AW-1:0];

  always_comb begin
    if (rom_hit)      region = REG_ROM;
    else if (ram_hit) region = REG_RAM;
    else              region = REG_EXT;
  end
endmodule

// File: rtl/pfr_offchip.sv
module pfr_offchip #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              ext_ready,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              busy,
  output logic              done,
  output logic              done_write,
  output logic [DATA_W-1:0] rdata_q,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata
);
  logic              active;
  logic              is_wr;
  logic [WAIT_W-1:0] cnt;

  assign busy       = active;
  assign done       = active && (cnt == '0) && ext_ready;
  assign done_write = is_wr;
  assign ext_rd     = active && !is_wr;
  assign ext_wr     = active && is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      is_wr     <= 1'b0;
      cnt       <= '0;
      ext_addr  <= '0;
      ext_wdata <= '0;
      rdata_q   <= '0;
    end else if (start) begin
      active    <= 1'b1;
      is_wr     <= start_write;
      cnt       <= wait_cfg;
      ext_addr  <= start_addr;
      ext_wdata <= start_wdata;
    end else if (active) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (done) begin
        active  <= 1'b0;
        rdata_q <= ext_rdata;
      end
    end
  end
endmodule

// File: rtl/pfetch_router.sv
module pfetch_router
  import pfr_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int ROM_BYTES = 1024,
  parameter int RAM_BYTES = 4096,
  parameter int WAIT_W    = 4,
  parameter int OFF_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              rom_en,
  output logic [OFF_W-1:0]  rom_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              ram_re,
  output logic              ram_we,
  output logic [OFF_W-1:0]  ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              ext_ready
);
  localparam int ROM_AW = (ROM_BYTES > 2) ? $clog2(ROM_BYTES) : 1;
  localparam int RAM_AW = (RAM_BYTES > 2) ? $clog2(RAM_BYTES) : 1;

  pfr_region_e       region;
  logic [ROM_AW-1:0] rom_off;
  logic [RAM_AW-1:0] ram_off;
  logic              accept;
  logic              ext_busy;
  logic              ext_done;
  logic              ext_done_wr;
  logic [DATA_W-1:0] ext_q;
  pfr_region_e       src_q;
  logic              wr_q;
  logic              vld_q;

  pfr_decode #(
    .ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES),
    .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)
  ) u_dec (
    .addr(req_addr), .region(region), .rom_off(rom_off), .ram_off(ram_off)
  );

  assign req_ready = !ext_busy;
  assign accept    = req_valid && req_ready;

  assign rom_en    = accept && (region == REG_ROM) && !req_write;
  assign ram_re    = accept && (region == REG_RAM) && !req_write;
  assign ram_we    = accept && (region == REG_RAM) && req_write;
  assign rom_addr  = OFF_W'(rom_off);
  assign ram_addr  = OFF_W'(ram_off);
  assign ram_wdata = req_wdata;

  pfr_offchip #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_ext (
    .clk(clk), .rst_n(rst_n),
    .start(accept && (region == REG_EXT)),
    .start_write(req_write), .start_addr(req_addr), .start_wdata(req_wdata),
    .wait_cfg(wait_cfg), .ext_ready(ext_ready), .ext_rdata(ext_rdata),
    .busy(ext_busy), .done(ext_done), .done_write(ext_done_wr), .rdata_q(ext_q),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_wdata(ext_wdata)
  );

  // one response per request: on-chip one cycle after accept, off-chip after done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      src_q <= REG_ROM;
      wr_q  <= 1'b0;
    end else if (ext_done) begin
      vld_q <= 1'b1;
      src_q <= REG_EXT;
      wr_q  <= ext_done_wr;
    end else if (accept && (region != REG_EXT)) begin
      vld_q <= 1'b1;
      src_q <= region;
      wr_q  <= req_write;
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign rsp_valid = vld_q;

  always_comb begin
    if (wr_q)                rsp_data = '0;
    else if (src_q == REG_ROM) rsp_data = rom_rdata;
    else if (src_q == REG_RAM) rsp_data = ram_rdata;
    else                     rsp_data = ext_q;
  end
endmodule

// File: rtl/pfr_chk.sv
module pfr_chk #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int ROM_BYTES = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rom_en,
  input logic              ram_we,
  input logic              ext_rd,
  input logic              ext_wr,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ext_ready
);
  logic rom_wr_acc;
  assign rom_wr_acc = req_valid && req_ready && req_write &&
                      (req_addr < ADDR_W'(ROM_BYTES));

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr));

  // R6
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) |-> !req_ready);

  // R4
  ext_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd && $past(ext_rd)) |-> $stable(ext_addr));

  // R5
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_rd || ext_wr) && !ext_ready) |=> !rsp_valid);

  // R3
  rom_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |=> rsp_valid);

  // R7
  ram_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (rsp_valid && rsp_data == '0));

  // R8
  ext_wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_wr) |-> (rsp_valid && rsp_data == '0));

  // R9
  rom_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_wr_acc |-> (!ram_we && !rom_en));

  // R9
  rom_wr_noext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_wr_acc |=> (!ext_wr && rsp_valid && rsp_data == '0));
endmodule

bind pfetch_router pfr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_BYTES(ROM_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .rom_en(rom_en), .ram_we(ram_we), .ext_rd(ext_rd),
  .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_ready(ext_ready)
);

// File: tb/sim_pfetch_router.sv
`timescale 1ns/1ps
module sim_pfetch_router;
  localparam int ROMB = 256;
  localparam int RAMB = 256;
  localparam int RAMBASE = 65536 - RAMB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [3:0]  wait_cfg = '0;
  logic        rom_en, ram_re, ram_we, ext_rd, ext_wr, ext_ready;
  logic [15:0] rom_addr, ram_addr;
  logic [7:0]  rom_rdata, ram_rdata, ram_wdata, ext_wdata, ext_rdata;
  logic [23:0] ext_addr;

  int total = 0;
  int fails = 0;
  int stall = 0;
  int act_cnt = 0;
  int n_ramwe = 0;
  int n_extwr = 0;
  logic [15:0] ramwe_addr;
  logic [7:0]  ramwe_data, extwr_data;
  logic [23:0] ext_seen, extwr_addr;
  logic [7:0]  mem [RAMB];
  logic [7:0]  exp_ram [RAMB];

  always #5 clk = ~clk;

  pfetch_router #(.ROM_BYTES(ROMB), .RAM_BYTES(RAMB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .wait_cfg(wait_cfg),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ready(ext_ready)
  );

  function automatic logic [7:0] ext_pat(logic [23:0] a);
    return a[7:0] + a[15:8] + a[23:16] + 8'h11;
  endfunction

  // memory models
  always @(posedge clk) begin
    if (rom_en) rom_rdata <= rom_addr[7:0] ^ 8'h5A;
    if (ram_we) begin
      mem[ram_addr[7:0]] <= ram_wdata;
      n_ramwe <= n_ramwe + 1; ramwe_addr <= ram_addr; ramwe_data <= ram_wdata;
    end
    if (ram_re) ram_rdata <= mem[ram_addr[7:0]];
    if (ext_rd) ext_seen <= ext_addr;
    if (ext_wr && ext_ready) begin
      n_extwr <= n_extwr + 1; extwr_addr <= ext_addr; extwr_data <= ext_wdata;
    end
    act_cnt <= (ext_rd || ext_wr) ? act_cnt + 1 : 0;
  end
  assign ext_rdata = ext_pat(ext_addr);
  assign ext_ready = (act_cnt >= stall);

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_data(logic [23:0] a);
    if (a < 24'(ROMB)) return a[7:0] ^ 8'h5A;
    if (a >= 24'(RAMBASE) && a <= 24'hFFFF) return exp_ram[a - 24'(RAMBASE)];
    return ext_pat(a);
  endfunction

  task automatic xfer(input logic [23:0] a, input bit wr, input logic [7:0] wd,
                      output logic [7:0] d, output int lat, output bit rdy1);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    lat = 1; rdy1 = req_ready;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk); lat++;
    end
    d = rsp_data;
  endtask

  initial begin
    #1500000;
    total++; fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int lat;
    bit rdy1;
    int ramwe0, extwr0;
    for (int i = 0; i < RAMB; i++) begin
      mem[i] = 8'(i) ^ 8'hC3; exp_ram[i] = 8'(i) ^ 8'hC3;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "strobes", {ext_rd, ext_wr, ram_we, rom_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", {rsp_valid, ext_rd, ext_wr}, 0);

    // R2 decode sweep around both on-chip regions, R3/R4 latency with no waits
    for (int a = 0; a < 768; a++) begin
      xfer(24'(a), 1'b0, 8'h0, d, lat, rdy1);
      chk("R2", "low data", d, exp_data(24'(a)));
      chk(a < ROMB ? "R3" : "R4", "low latency", lat, a < ROMB ? 1 : 2);
    end
    for (int a = 65536 - 768; a < 65536; a++) begin
      xfer(24'(a), 1'b0, 8'h0, d, lat, rdy1);
      chk("R2", "top data", d, exp_data(24'(a)));
      chk(a >= RAMBASE ? "R3" : "R4", "top latency", lat, a >= RAMBASE ? 1 : 2);
    end
    for (int k = 0; k < 6; k++) begin
      logic [23:0] a;
      a = (k == 0) ? 24'h010000 : (k == 1) ? 24'h0100FF : (k == 2) ? 24'h01FF00 :
          (k == 3) ? 24'h800000 : (k == 4) ? 24'hFFFFFF : 24'h12FFF0;
      xfer(a, 1'b0, 8'h0, d, lat, rdy1);
      chk("R2", "above 64K data", d, ext_pat(a));
      chk("R4", "above 64K addr", ext_seen, a);
    end

    // R4/R5/R6 wait count against ready delay
    for (int w = 0; w < 8; w++) begin
      for (int s = 0; s < 10; s++) begin
        logic [23:0] a;
        a = 24'h4000 + 24'(w * 16 + s);
        wait_cfg = 4'(w); stall = s;
        xfer(a, 1'b0, 8'h0, d, lat, rdy1);
        chk(s > w ? "R5" : "R4", "ext latency", lat, 2 + ((s > w) ? s : w));
        chk("R4", "ext data", d, ext_pat(a));
        chk("R4", "ext addr", ext_seen, a);
        chk("R6", "ready low while open", rdy1, 0);
      end
    end
    wait_cfg = '0; stall = 0;

    // R7 RAM write and read-back
    xfer(24'hFF10, 1'b1, 8'hA7, d, lat, rdy1);
    exp_ram[8'h10] = 8'hA7;
    chk("R7", "ack data", d, 0);
    chk("R7", "ack latency", lat, 1);
    chk("R7", "ram offset", ramwe_addr, 16'h10);
    chk("R7", "ram data", ramwe_data, 8'hA7);
    xfer(24'hFF10, 1'b0, 8'h0, d, lat, rdy1);
    chk("R7", "read-back", d, 8'hA7);

    // R9 ROM write ignored
    ramwe0 = n_ramwe; extwr0 = n_extwr;
    xfer(24'h0033, 1'b1, 8'hEE, d, lat, rdy1);
    chk("R9", "ack data", d, 0);
    chk("R9", "ack latency", lat, 1);
    chk("R9", "no ram_we", n_ramwe, ramwe0);
    chk("R9", "no ext_wr", n_extwr, extwr0);
    xfer(24'h0033, 1'b0, 8'h0, d, lat, rdy1);
    chk("R9", "rom unchanged", d, 8'h33 ^ 8'h5A);

    // R8 off-chip write with waits
    wait_cfg = 4'd1; stall = 3;
    xfer(24'h2ABCDE, 1'b1, 8'h96, d, lat, rdy1);
    chk("R8", "ack data", d, 0);
    chk("R8", "latency", lat, 5);
    chk("R8", "addr", extwr_addr, 24'h2ABCDE);
    chk("R8", "data", extwr_data, 8'h96);
    chk("R8", "one write", n_extwr, extwr0 + 1);
    wait_cfg = '0; stall = 0;

    // R3 back-to-back ROM reads: response and next accept in one cycle
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'h10; req_write = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R3", "first rsp", {rsp_valid, rsp_data}, {1'b1, 8'h10 ^ 8'h5A});
    chk("R3", "ready kept", req_ready, 1);
    req_addr = 24'h20;
    @(posedge clk); @(negedge clk);
    chk("R3", "second rsp", {rsp_valid, rsp_data}, {1'b1, 8'h20 ^ 8'h5A});
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10", "single pulse", rsp_valid, 0);

    // R7 RAM write then immediate read of the same byte
    req_valid = 1'b1; req_addr = 24'hFF40; req_write = 1'b1; req_wdata = 8'h3C;
    @(posedge clk); @(negedge clk);
    chk("R7", "ack in overlap", {rsp_valid, rsp_data}, {1'b1, 8'h00});
    req_write = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7", "new data next", {rsp_valid, rsp_data}, {1'b1, 8'h3C});
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10", "no extra pulse", rsp_valid, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule